// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines, ranks them by a fixed priority and raises a single interrupt output towards a processor. Software reaches it through two byte addresses: a command address and a data address. A short sequence of setup bytes programs the vector base, the cascade configuration byte and the end-of-interrupt mode. After setup, the data address holds the mask. The command address accepts end-of-interrupt commands for a chosen level and selects which status byte a command-address read returns.

When the processor pulses the acknowledge input, the controller answers on the next cycle with a vector byte: the programmed base plus the index of the winning input. The winning level is then recorded as in service, unless automatic end-of-interrupt is enabled. If no eligible request remains at acknowledge time, the controller gives the vector for input 7 and leaves the in-service state alone. To build a two-level cascade, instantiate the block twice.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the pending and in-service bytes are 0x00, the mask byte is 0xFF, `int_o` is low, and a command-address read returns the pending byte.
- R2: A command-address write with bit 4 set starts setup. The next three data-address writes are taken in order as the vector base, the cascade byte (shown on `casc_o`) and the mode byte. Every data-address write after that loads the mask byte.
- R3: Each one-cycle `ack_i` pulse produces `vec_valid_o` high for exactly the next cycle, with `vec_o` = vector base + index of the winning input, modulo 256.
- R4: Priority is fixed. Among unmasked pending inputs, the lowest index wins.
- R5: `int_o` is high only when some unmasked pending input has a lower index than every in-service bit. A higher-priority request therefore interrupts a lower one that is still in service.
- R6: A command-address write of 0x60+L (L in 0..7) clears in-service bit L and no other bit.
- R7: A command-address write of 0x0A selects the pending byte and 0x0B selects the in-service byte for later command-address reads. The choice holds until it is changed. A data-address read returns the mask byte. Read data appears on `rdata_o` one cycle after the `rd_i` strobe.
- R8: A masked input still shows in the pending byte, but it never raises `int_o` and never sets its in-service bit.
- R9: An acknowledge with no eligible request returns vector base + 7 and leaves the in-service byte unchanged. This also holds while input 7 is masked.
- R10: When bit 1 of the mode byte is set, an acknowledge sets no in-service bit.
- R11: Each request passes through two flip-flops. An unmasked request raises `int_o` on the second rising edge after it is asserted, and a dropped request leaves the pending byte by the same path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Level-sensitive interrupt request lines |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| addr_i | input | 1 | 0 selects the command address, 1 selects the data address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| vec_valid_o | output | 1 | High for the one cycle that carries the vector |
| vec_o | output | 8 | Resolved vector byte |
| int_o | output | 1 | Interrupt request to the processor |
| casc_o | output | 8 | Programmed cascade configuration byte |

## Verification
The bench covers the following corner cases:
- A lower-priority request that is already in service must hold back the interrupt output, while a higher-priority arrival must break through. A design that compared against the wrong end of the in-service byte would either stall or nest in the wrong direction.
- A request that disappears just before acknowledge must yield the input-7 vector without any in-service bit. A design that latched the earlier winner would leave a level stuck in service.
- Masked inputs must stay visible in the pending readback but stay out of service.
- Automatic end-of-interrupt must leave the in-service byte empty.
- The setup sequence must route its three bytes to the right fields before the mask becomes writable. A design that miscounted the sequence would corrupt the vector base or the mask.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW   = 8;
  localparam int NIRQ = DW;
  localparam int IDXW = $clog2(NIRQ);

  localparam int         START_BIT  = 4;
  localparam int         AUTO_BIT   = 1;
  localparam logic [7:0] SEL_PEND   = 8'h0A;
  localparam logic [7:0] SEL_SERV   = 8'h0B;
  localparam logic [4:0] EOI_PREFIX = 5'b01100;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } setup_t;

  // Index of the lowest set bit (highest priority); 0 when none is set.
  function automatic logic [IDXW-1:0] top_level(input logic [NIRQ-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (v[i]) r = IDXW'(i);
    return r;
  endfunction

  function automatic logic [DW-1:0] make_vector(input logic [DW-1:0] base,
                                                input logic [IDXW-1:0] idx);
    return base + DW'(idx);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   base_o,
  output logic [DW-1:0]   casc_o,
  output logic            auto_eoi_o,
  output logic [NIRQ-1:0] mask_o,
  output logic            show_serv_o,
  output logic            setup_start_o,
  output logic            eoi_hit_o,
  output logic [IDXW-1:0] eoi_lvl_o
);
  setup_t state;
  logic   cmd_wr, dat_wr;

  assign cmd_wr        = wr_i && !addr_i;
  assign dat_wr        = wr_i && addr_i;
  assign setup_start_o = cmd_wr && wdata_i[START_BIT];
  assign eoi_hit_o     = cmd_wr && (wdata_i[7:3] == EOI_PREFIX);
  assign eoi_lvl_o     = wdata_i[IDXW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      base_o      <= '0;
      casc_o      <= '0;
      auto_eoi_o  <= 1'b0;
      mask_o      <= '1;
      show_serv_o <= 1'b0;
    end else begin
      if (setup_start_o) begin
        state <= ST_BASE;
      end else if (cmd_wr) begin
        if (wdata_i == SEL_PEND) show_serv_o <= 1'b0;
        if (wdata_i == SEL_SERV) show_serv_o <= 1'b1;
      end
      if (dat_wr) begin
        unique case (state)
          ST_BASE: begin base_o <= wdata_i; state <= ST_CASC; end
          ST_CASC: begin casc_o <= wdata_i; state <= ST_MODE; end
          ST_MODE: begin auto_eoi_o <= wdata_i[AUTO_BIT]; state <= ST_RUN; end
          default: mask_o <= wdata_i[NIRQ-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_pkg::*;
(
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] mask_i,
  input  logic [NIRQ-1:0] serv_i,
  output logic [NIRQ-1:0] elig_o,
  output logic            fire_o,
  output logic [IDXW-1:0] win_o
);
  logic [IDXW-1:0] serv_top;

  assign elig_o   = pend_i & ~mask_i;
  assign win_o    = top_level(elig_o);
  assign serv_top = top_level(serv_i);
  assign fire_o   = (|elig_o) && ((serv_i == '0) || (win_o < serv_top));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    req_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          ack_i,
  output logic          vec_valid_o,
  output logic [7:0]    vec_o,
  output logic          int_o,
  output logic [7:0]    casc_o
);
  logic [NIRQ-1:0] pend_w, mask_w, serv_q, serv_d, elig_w, eoi_mask_w;
  logic [DW-1:0]   base_w;
  logic [IDXW-1:0] win_w, eoi_lvl_w;
  logic            auto_w, show_serv_w, setup_start_w, eoi_hit_w, fire_w;
  logic            take_w;

  irq_sync #(.WIDTH(NIRQ)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(req_i), .q(pend_w)
  );

  irq_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .base_o(base_w), .casc_o(casc_o), .auto_eoi_o(auto_w), .mask_o(mask_w),
    .show_serv_o(show_serv_w), .setup_start_o(setup_start_w),
    .eoi_hit_o(eoi_hit_w), .eoi_lvl_o(eoi_lvl_w)
  );

  irq_resolve res_i (
    .pend_i(pend_w), .mask_i(mask_w), .serv_i(serv_q),
    .elig_o(elig_w), .fire_o(fire_w), .win_o(win_w)
  );

  assign int_o      = fire_w;
  assign take_w     = ack_i && fire_w;
  assign eoi_mask_w = eoi_hit_w ? (NIRQ'(1) << eoi_lvl_w) : '0;

  always_comb begin
    serv_d = serv_q & ~eoi_mask_w;
    if (take_w && !auto_w) serv_d[win_w] = 1'b1;
    if (setup_start_w) serv_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serv_q      <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
      rdata_o     <= '0;
    end else begin
      serv_q      <= serv_d;
      vec_valid_o <= ack_i;
      if (ack_i)
        vec_o <= make_vector(base_w, take_w ? win_w : IDXW'(NIRQ - 1));
      if (rd_i)
        rdata_o <= addr_i ? mask_w : (show_serv_w ? serv_q : pend_w);
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ack_i,
  input logic            vec_valid_o,
  input logic            int_o,
  input logic [NIRQ-1:0] pend,
  input logic [NIRQ-1:0] mask,
  input logic [NIRQ-1:0] serv,
  input logic            auto_eoi,
  input logic            eoi_hit,
  input logic [NIRQ-1:0] eoi_mask
);
  AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o); // R3
  AST_VEC_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(ack_i)); // R3
  AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((pend & ~mask) != '0)); // R8
  AST_SERV_SET_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((serv & ~$past(serv)) & ~$past(pend & ~mask)) == '0); // R8
  AST_AUTO_NO_SERV: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_eoi && $past(auto_eoi)) |-> ((serv & ~$past(serv)) == '0)); // R10
  AST_EOI_CLEARS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !ack_i) |=> ((serv & $past(eoi_mask)) == '0)); // R6
endmodule

bind prio_irq_ctrl prio_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .vec_valid_o(vec_valid_o),
  .int_o(int_o), .pend(pend_w), .mask(mask_w), .serv(serv_q),
  .auto_eoi(auto_w), .eoi_hit(eoi_hit_w), .eoi_mask(eoi_mask_w)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0, ack_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, vec_o, casc_o;
  logic       vec_valid_o, int_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o), .int_o(int_o), .casc_o(casc_o)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_i = 1'b1; addr_i = a;
    @(negedge clk); rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic ack(input string tag, input logic [7:0] exp);
    @(negedge clk); ack_i = 1'b1; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); ack_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever a vector appears.
  always @(negedge clk) begin
    if (rst_n && vec_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3: unexpected vector 0x%02h expected none", vec_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        check(t, vec_o, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 int_o", {7'b0, int_o}, 8'h00);
    rd(1'b0, r); check("R1 pending", r, 8'h00);
    rd(1'b1, r); check("R1 mask", r, 8'hFF);

    // Setup: base 0x20, cascade 0x04, normal EOI mode
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    check("R2 cascade", casc_o, 8'h04);
    wr(1'b1, 8'h00);
    rd(1'b1, r); check("R2 mask load", r, 8'h00);

    // R11: two-flop delay
    @(negedge clk); req_i = 8'h08;
    @(negedge clk); check("R11 after 1 edge", {7'b0, int_o}, 8'h00);
    @(negedge clk); check("R11 after 2 edges", {7'b0, int_o}, 8'h01);

    // R3/R4: inputs 3 and 5 pending, 3 wins
    req_i = 8'h28; settle();
    ack("R3 R4 vector", 8'h23);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R7 serv readback", r, 8'h08);
    check("R5 blocked by serv", {7'b0, int_o}, 8'h00);

    // R5: higher-priority input 1 nests
    req_i = 8'h2A; settle();
    check("R5 nesting", {7'b0, int_o}, 8'h01);
    ack("R4 nested vector", 8'h21);
    rd(1'b0, r); check("R5 serv nested", r, 8'h0A);

    // R6: specific EOI
    wr(1'b0, 8'h61);
    rd(1'b0, r); check("R6 eoi level 1", r, 8'h08);
    wr(1'b0, 8'h63);
    rd(1'b0, r); check("R6 eoi level 3", r, 8'h00);

    // R7: pending readback persists
    req_i = 8'h00; settle();
    wr(1'b0, 8'h0A);
    req_i = 8'h10; settle();
    rd(1'b0, r); check("R7 pending sel", r, 8'h10);
    rd(1'b0, r); check("R7 selection holds", r, 8'h10);

    // R9: request drops before acknowledge
    req_i = 8'h00; settle();
    ack("R9 spurious vector", 8'h27);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R9 serv unchanged", r, 8'h00);

    // R8: masked input
    wr(1'b1, 8'hFF);
    req_i = 8'h04; settle();
    check("R8 no int", {7'b0, int_o}, 8'h00);
    wr(1'b0, 8'h0A);
    rd(1'b0, r); check("R8 pending visible", r, 8'h04);
    ack("R9 spurious while 7 masked", 8'h27);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R8 serv not set", r, 8'h00);

    // R10: automatic EOI with new base
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h02); wr(1'b1, 8'h03);
    check("R2 cascade reprogram", casc_o, 8'h02);
    wr(1'b1, 8'h00); settle();
    ack("R3 R10 vector", 8'h42);
    rd(1'b0, r); check("R10 serv empty", r, 8'h00);
    check("R10 int stays", {7'b0, int_o}, 8'h01);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R3: got %0d pending vectors expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule